// File: doc/BRIEF.md
# Bipolar Stepper Phase Sequencer

This block turns step requests into switch commands for the two coils of a two-phase bipolar stepper motor. Each rising edge seen on the step input advances an internal phase index one position. The direction input picks the order, and the step-mode input picks whole steps or half steps. Each of the four coil terminals has a high-side enable and a low-side enable. A terminal can therefore be pulled high, pulled low or left floating. An active-low home indication goes low whenever the sequencer sits in phase A.

In half-step mode, every other phase energizes only one coil. The idle-coil control then either floats both terminals of that coil or clamps both of them high. A set input returns the sequencer to phase A and floats every terminal. While set is high, step edges and mode inputs have no effect. Once set is released, the drivers come back in the phase A pattern. All inputs are synchronous to `clk`. The power stage that follows the block decodes the enables.

Top module: `stp_phase_seq`

## Requirements
- R1: After reset, the block is in phase A. hi_en_o = 4'b0101 and lo_en_o = 4'b1010 (bit 0 is terminal 1, bit 3 is terminal 4). home_n_o is 0.
- R2: In half-step mode with ccw_i = 0, each step advances through eight phases. Coil 1 (terminals 1/2) and coil 2 (terminals 3/4) follow (+,+) (0,+) (−,+) (−,0) (−,−) (0,−) (+,−) (+,0) and then wrap. "+" drives the lower-numbered terminal high and the other low. "−" does the reverse. "0" means the coil is idle.
- R3: In half-step mode with ccw_i = 1, each step walks the R2 order backwards.
- R4: In full-step mode with ccw_i = 0 and starting from phase A, steps visit (+,+) (−,+) (−,−) (+,−). Both coils are energized in every phase.
- R5: In full-step mode with ccw_i = 1, the R4 order runs in reverse.
- R6: A full step taken from a single-coil phase lands on the neighbouring two-coil phase in the selected direction.
- R7: In half-step mode with idle_hold_i = 0, both terminals of the idle coil are floating (both enables 0).
- R8: In half-step mode with idle_hold_i = 1, both terminals of the idle coil have only the high side enabled. In full-step mode, an idle coil floats whatever idle_hold_i is.
- R9: While set_i = 1, all enables are 0 and home_n_o = 0. Step edges are ignored.
- R10: After set_i falls, the outputs show the phase A pattern. A step level already high at release does not count as an edge. Only a later rising edge advances the phase.
- R11: The phase advances once for each rising edge of step_i, no matter how long step_i stays high. The new phase appears on the outputs after the clock edge that samples step_i high.
- R12: No terminal ever has its high-side and low-side enables asserted together.
- R13: home_n_o is 0 exactly when the phase is A or set_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Step request, advances on each rising level change |
| ccw_i | input | 1 | 0 = clockwise order, 1 = counter-clockwise |
| half_i | input | 1 | 0 = full step, 1 = half step |
| idle_hold_i | input | 1 | Idle coil in half step: 0 = float, 1 = clamp high |
| set_i | input | 1 | Force phase A and float all terminals |
| hi_en_o | output | 4 | High-side enable per terminal |
| lo_en_o | output | 4 | Low-side enable per terminal |
| home_n_o | output | 1 | Low while in phase A |

## Verification
The bench sends both half-step directions through a full eight-phase cycle, once with the idle coil floating and once with it clamped. This separates the polarity order from the idle-coil handling. It runs full-step walks in both directions from phase A, and it switches to full step from an odd half-step phase in each direction. These two cases tell the even/odd rounding rule apart from a plain stride of two. A step level held high across several clocks, and another held high across the release of set, check that only rising edges count. Every sample also confirms that no terminal has both enables on and that the home flag agrees with the phase.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int IDX_W  = 3;
  localparam int COILS  = 2;
  localparam int TERMS  = 2 * COILS;
  // phase offset between successive coils, in half-step positions
  localparam int COIL_SKEW = 2;

  typedef enum logic [1:0] {POL_OFF, POL_POS, POL_NEG} pol_e;

  // polarity of coil 0 at half-step position j
  function automatic pol_e base_pol(input logic [IDX_W-1:0] j);
    case (j)
      3'd6, 3'd7, 3'd0: base_pol = POL_POS;
      3'd2, 3'd3, 3'd4: base_pol = POL_NEG;
      default:          base_pol = POL_OFF;
    endcase
  endfunction
endpackage

// File: rtl/stp_edge.sv
module stp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic set_i,
  output logic fire_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= step_i;
  end

  assign fire_o = step_i & ~prev_q & ~set_i;

  // R11: two consecutive cycles never both produce an advance
  a_r11_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);
endmodule

// File: rtl/stp_index.sv
module stp_index
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             fire_i,
  input  logic             ccw_i,
  input  logic             half_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q, delta, idx_nx;

  always_comb begin
    delta  = (half_i || idx_q[0]) ? IDX_W'(1) : IDX_W'(2);
    idx_nx = ccw_i ? (idx_q - delta) : (idx_q + delta);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || set_i) idx_q <= '0;
    else if (fire_i)     idx_q <= idx_nx;
  end

  assign idx_o = idx_q;

  a_r9_set_home: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> idx_q == '0);
  a_r11_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire_i && !set_i) |=> $stable(idx_q));
  a_r2_half_cw: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && half_i && !ccw_i && !set_i) |=> idx_q == $past(idx_q) + IDX_W'(1));
  a_r6_full_even: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !half_i && !set_i) |=> !idx_q[0]);
endmodule

// File: rtl/stp_drive.sv
module stp_drive
  import stp_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  input  logic             set_i,
  input  logic             half_i,
  input  logic             hold_i,
  output logic [TERMS-1:0] hi_o,
  output logic [TERMS-1:0] lo_o
);
  for (genvar c = 0; c < COILS; c++) begin : g_coil
    pol_e pol;
    logic [IDX_W-1:0] pos;
    assign pos = idx_i - IDX_W'(COIL_SKEW * c);
    assign pol = base_pol(pos);

    always_comb begin
      hi_o[2*c+:2] = 2'b00;
      lo_o[2*c+:2] = 2'b00;
      if (!set_i) begin
        case (pol)
          POL_POS: begin hi_o[2*c+:2] = 2'b01; lo_o[2*c+:2] = 2'b10; end
          POL_NEG: begin hi_o[2*c+:2] = 2'b10; lo_o[2*c+:2] = 2'b01; end
          default: if (half_i && hold_i) hi_o[2*c+:2] = 2'b11;
        endcase
      end
    end
  end

  // R12: complementary enables never overlap
  always_comb a_r12_no_overlap: assert ((hi_o & lo_o) == '0);
endmodule

// File: rtl/stp_phase_seq.sv
module stp_phase_seq
  import stp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             ccw_i,
  input  logic             half_i,
  input  logic             idle_hold_i,
  input  logic             set_i,
  output logic [TERMS-1:0] hi_en_o,
  output logic [TERMS-1:0] lo_en_o,
  output logic             home_n_o
);
  logic             fire;
  logic [IDX_W-1:0] idx;

  stp_edge u_edge (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .set_i(set_i), .fire_o(fire)
  );

  stp_index u_index (
    .clk(clk), .rst_n(rst_n), .set_i(set_i), .fire_i(fire),
    .ccw_i(ccw_i), .half_i(half_i), .idx_o(idx)
  );

  stp_drive u_drive (
    .idx_i(idx), .set_i(set_i), .half_i(half_i), .hold_i(idle_hold_i),
    .hi_o(hi_en_o), .lo_o(lo_en_o)
  );

  assign home_n_o = ~(set_i || idx == '0);

  a_r9_set_float: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> (hi_en_o == '0 && lo_en_o == '0 && !home_n_o));
  a_r13_home_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (!home_n_o && !set_i) |-> (hi_en_o == 4'b0101 && lo_en_o == 4'b1010));
  a_r12_port_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_en_o & lo_en_o) == '0);
endmodule

// File: tb/tb_stp_phase_seq.sv
module tb_stp_phase_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_i = 1'b0, ccw_i = 1'b0, half_i = 1'b0, idle_hold_i = 1'b0, set_i = 1'b0;
  logic [3:0] hi_en_o, lo_en_o;
  logic home_n_o;
  int checks = 0, failures = 0;
  int eidx = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stp_phase_seq dut (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .ccw_i(ccw_i), .half_i(half_i),
    .idle_hold_i(idle_hold_i), .set_i(set_i),
    .hi_en_o(hi_en_o), .lo_en_o(lo_en_o), .home_n_o(home_n_o)
  );

  // expected polarity (+1, 0, -1) of coil k at phase p, from the R2 order
  function automatic int pol_of(input int p, input int k);
    if (k == 0) case (p) 0, 6, 7: return 1; 2, 3, 4: return -1; default: return 0; endcase
    else        case (p) 0, 1, 2: return 1; 4, 5, 6: return -1; default: return 0; endcase
  endfunction

  task automatic check(input string req);
    logic [3:0] eh, el;
    logic eh_n;
    eh = 4'b0; el = 4'b0;
    if (!set_i) begin
      for (int k = 0; k < 2; k++) begin
        int pl = pol_of(eidx, k);
        if (pl == 1)       begin eh[2*k] = 1'b1; el[2*k+1] = 1'b1; end
        else if (pl == -1) begin eh[2*k+1] = 1'b1; el[2*k] = 1'b1; end
        else if (half_i && idle_hold_i) begin eh[2*k] = 1'b1; eh[2*k+1] = 1'b1; end
      end
    end
    eh_n = !(set_i || eidx == 0);
    checks++;
    if (hi_en_o !== eh || lo_en_o !== el || home_n_o !== eh_n) begin
      failures++;
      $display("FAIL %s phase=%0d hi=%b lo=%b home_n=%b expected hi=%b lo=%b home_n=%b",
               req, eidx, hi_en_o, lo_en_o, home_n_o, eh, el, eh_n);
    end
    checks++;
    if ((hi_en_o & lo_en_o) !== 4'b0) begin
      failures++;
      $display("FAIL R12 overlap hi=%b lo=%b expected no common bit", hi_en_o, lo_en_o);
    end
  endtask

  // one step pulse; model advances only when set is low
  task automatic pulse();
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
    if (!set_i) begin
      int d = (half_i || (eidx % 2 == 1)) ? 1 : 2;
      eidx = ccw_i ? (eidx - d + 8) % 8 : (eidx + d) % 8;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1");
  endtask

  task automatic t_half_cw();
    half_i = 1'b1; ccw_i = 1'b0; idle_hold_i = 1'b0;
    for (int i = 0; i < 8; i++) begin pulse(); check("R2_R7"); end
    idle_hold_i = 1'b1;
    for (int i = 0; i < 8; i++) begin pulse(); check("R8"); end
  endtask

  task automatic t_half_ccw();
    half_i = 1'b1; ccw_i = 1'b1; idle_hold_i = 1'b0;
    for (int i = 0; i < 8; i++) begin pulse(); check("R3"); end
  endtask

  task automatic t_full();
    half_i = 1'b0; ccw_i = 1'b0;
    for (int i = 0; i < 4; i++) begin pulse(); check("R4"); end
    ccw_i = 1'b1;
    for (int i = 0; i < 4; i++) begin pulse(); check("R5"); end
  endtask

  task automatic t_odd_entry();
    half_i = 1'b1; ccw_i = 1'b0; idle_hold_i = 1'b1;
    pulse(); check("R2");
    half_i = 1'b0; @(negedge clk); check("R8_full_float");
    pulse(); check("R6_cw");
    half_i = 1'b1; pulse(); check("R2");
    half_i = 1'b0; ccw_i = 1'b1; pulse(); check("R6_ccw");
  endtask

  task automatic t_set();
    half_i = 1'b1; ccw_i = 1'b0;
    pulse(); pulse(); check("R2");
    set_i = 1'b1; @(negedge clk); eidx = 0; check("R9_float");
    pulse(); check("R9_ignore");
    half_i = 1'b0; ccw_i = 1'b1; pulse(); check("R9_ignore");
    step_i = 1'b1; @(negedge clk);
    set_i = 1'b0; @(negedge clk); check("R10_release");
    @(negedge clk); check("R10_level_ignored");
    step_i = 1'b0; @(negedge clk);
    half_i = 1'b1; ccw_i = 1'b0; pulse(); check("R10_resume");
  endtask

  task automatic t_hold_level();
    half_i = 1'b1; ccw_i = 1'b0;
    step_i = 1'b1; eidx = (eidx + 1) % 8;
    for (int i = 0; i < 5; i++) begin @(negedge clk); check("R11"); end
    step_i = 1'b0; @(negedge clk); check("R11");
    pulse(); check("R13");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_half_cw();
    t_half_ccw();
    t_full();
    t_odd_entry();
    t_set();
    t_hold_level();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule